// File: doc/BRIEF.md
# SMBus Host Transaction Sequencer

This block drives the host side of an SMBus one byte at a time. A client hands it one request: the transaction type, the 7-bit target address, a command byte, a write payload and, for block writes, a byte count. The sequencer expands the request into the exact chain of bus primitives that the chosen framing needs. It places the repeated start, the count bytes and the acknowledge decisions. It issues those primitives to a separate bit-level engine, one at a time. It gathers any bytes read back. When the transaction ends, it raises a one-cycle completion pulse with a status code.

Eleven framings are decoded. They are quick command, send byte, receive byte, byte write and read, word write and read, process call, block write and read, and block process call. All of them share one state machine. A small decoder turns the request type into framing flags: whether a command byte follows, whether a count byte is written, whether the read phase has a device-supplied count, and whether the first address already carries the read direction.

The bit engine works in five primitives: start, repeated start, write byte, read byte, and stop. A separate acknowledge primitive follows every read byte. This lets the host decide ACK or NACK after it has seen the byte, which the block count check requires.

Top module: `smbus_seq_top`

## Requirements
- R1: `req_ready` is high only while the block is idle, including straight after reset. A request is taken when `req_valid` and `req_ready` are both high. `done` is a one-cycle pulse, and in that cycle `status`, `err_idx`, `rsp_len` and `rsp_data` are final. Status 0 means success. The block is ready again in the cycle after `done`.
- R2: Primitive codes on `op_code` are 0 start, 1 repeated start, 2 write byte, 3 read byte, 4 acknowledge and 5 stop. `op_code`, `op_byte` and `op_nack` stay steady from the cycle `op_valid` rises until `op_done` closes the primitive. On a write, `op_ack`=1 means the target acknowledged. On an acknowledge primitive, `op_nack`=1 sends NACK.
- R3: An address byte is the 7-bit address in bits 7..1 and the direction in bit 0, with read=1 and write=0. Quick command (type 0) sends start, the address byte with direction taken from `req_cmd[0]`, and stop. No data byte is sent.
- R4: Send byte (type 1) writes the address with write direction and then write byte 0 of `req_wdata`. Receive byte (type 2) writes the address with read direction and reads one byte, which it NACKs. Write byte k of `req_wdata` is bits 8k+7..8k.
- R5: Byte write (type 3) and word write (type 5) send the address with write direction, then the command, then one or two data bytes in order, with the low byte first.
- R6: Byte read (type 4) and word read (type 6) send the address with write direction and the command. They then issue a repeated start and the address with read direction. Each received byte is followed by an acknowledge primitive: ACK for every byte except the last, which gets NACK. Read byte k lands in `rsp_data` bits 8k+7..8k, so the low byte of a word is at index 0.
- R7: Process call (type 7) writes the command and a two-byte word, low byte first. After a repeated start, it reads a two-byte word back.
- R8: Block write (type 8) sends the command, then `req_len` as a count byte, then that many data bytes. A block write with `req_len` of 0 or above MAX_BLOCK is rejected with status 7 and no bus primitive. So is a block process call with `req_len` of 0 or above MAX_BLOCK-1, and so is a type above 10.
- R9: Block read (type 9) sends the address with write direction and the command, then a repeated start and the address with read direction. The first byte read is a count, and it is ACKed. Exactly that many data bytes then follow. `rsp_len` equals the count, which may be as large as MAX_BLOCK.
- R10: Block process call (type 10) does a block write phase followed by a block read phase, joined by a repeated start. The returned count may be at most MAX_BLOCK-1.
- R11: A NACK on any written byte makes the next primitive a stop and ends with a status naming the byte that failed. The codes are 1 for the first address, 2 for the command, 3 for the write count, 4 for a data byte and 5 for the address after the repeated start. For status 4, `err_idx` holds the index of the failing data byte; otherwise `err_idx` is 0.
- R12: A returned count of 0, or one above the type's limit, is NACKed. Stop follows at once, no further byte is read, the status is 6 and `rsp_len` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_type | input | 4 | Transaction type code 0..10 |
| req_addr | input | 7 | Target address |
| req_cmd | input | 8 | Command byte, bit 0 is direction for quick command |
| req_len | input | CW | Block write byte count |
| req_wdata | input | MAX_BLOCK*8 | Write payload, byte k at bits 8k+7..8k |
| op_valid | output | 1 | Primitive pending for the bit engine |
| op_code | output | 3 | Primitive code |
| op_byte | output | 8 | Byte to write |
| op_nack | output | 1 | NACK select for acknowledge primitive |
| op_done | input | 1 | Bit engine finished the current primitive |
| op_ack | input | 1 | Target acknowledged the written byte |
| op_rbyte | input | 8 | Byte read by the bit engine |
| done | output | 1 | Transaction end pulse |
| status | output | 3 | Completion code |
| err_idx | output | CW | Index of the data byte that was NACKed |
| rsp_len | output | CW | Number of bytes read |
| rsp_data | output | MAX_BLOCK*8 | Read bytes, byte k at bits 8k+7..8k |

## Verification
The assertions assume that the bit engine raises `op_done` for exactly one cycle per primitive and only while `op_valid` is high. They also assume that the engine never finishes a primitive that was not offered. The bench engine model respects this: it answers each primitive once, lowers `op_done` on the following falling edge, and waits a cycle before it looks at the next primitive. Requests are offered only while the block is idle and are withdrawn right after the edge that takes them. Count bytes the model returns sit both inside and outside the legal range.

// File: rtl/smbus_seq_pkg.sv
package smbus_seq_pkg;

   // transaction types
   localparam logic [3:0] TX_QUICK = 4'd0;
   localparam logic [3:0] TX_SEND  = 4'd1;
   localparam logic [3:0] TX_RECV  = 4'd2;
   localparam logic [3:0] TX_WRB   = 4'd3;
   localparam logic [3:0] TX_RDB   = 4'd4;
   localparam logic [3:0] TX_WRW   = 4'd5;
   localparam logic [3:0] TX_RDW   = 4'd6;
   localparam logic [3:0] TX_PCALL = 4'd7;
   localparam logic [3:0] TX_BWR   = 4'd8;
   localparam logic [3:0] TX_BRD   = 4'd9;
   localparam logic [3:0] TX_BPC   = 4'd10;

   // bit-engine primitives
   localparam logic [2:0] OP_START  = 3'd0;
   localparam logic [2:0] OP_RSTART = 3'd1;
   localparam logic [2:0] OP_WRITE  = 3'd2;
   localparam logic [2:0] OP_READ   = 3'd3;
   localparam logic [2:0] OP_ACK    = 3'd4;
   localparam logic [2:0] OP_STOP   = 3'd5;

   // completion codes
   localparam logic [2:0] SC_OK      = 3'd0;
   localparam logic [2:0] SC_NK_ADR  = 3'd1;
   localparam logic [2:0] SC_NK_CMD  = 3'd2;
   localparam logic [2:0] SC_NK_CNT  = 3'd3;
   localparam logic [2:0] SC_NK_DAT  = 3'd4;
   localparam logic [2:0] SC_NK_ADR2 = 3'd5;
   localparam logic [2:0] SC_BAD_CNT = 3'd6;
   localparam logic [2:0] SC_BAD_REQ = 3'd7;

   typedef struct packed {
      logic quick;     // address only
      logic first_rd;  // first address already carries read
      logic has_cmd;   // command byte follows address
      logic has_wcnt;  // count byte precedes write data
      logic has_rd;    // read phase after repeated start
      logic rd_block;  // read phase begins with a count
   } frame_t;

   typedef enum logic [3:0] {
      S_IDLE, S_START, S_ADDR1, S_CMD, S_WCNT, S_WDATA, S_RSTART,
      S_ADDR2, S_RCNT, S_RCACK, S_RD, S_RDACK, S_STOP, S_DONE
   } seq_state_e;

endpackage

// File: rtl/smbus_seq_frame.sv
module smbus_seq_frame
   import smbus_seq_pkg::*;
#(
   parameter int MAX_BLOCK = 32,
   parameter int CW        = $clog2(MAX_BLOCK + 1)
) (
   input  logic [3:0]    typ,
   input  logic [CW-1:0] blen,
   output frame_t        fr,
   output logic [CW-1:0] wlen,
   output logic [CW-1:0] rfix,
   output logic [CW-1:0] rmax,
   output logic          len_ok
);

   logic known;

   always_comb begin
      fr    = '0;
      wlen  = '0;
      rfix  = '0;
      known = 1'b1;
      case (typ)
         TX_QUICK: fr.quick = 1'b1;
         TX_SEND:  wlen = CW'(1);
         TX_RECV: begin
            fr.first_rd = 1'b1;
            rfix        = CW'(1);
         end
         TX_WRB: begin
            fr.has_cmd = 1'b1;
            wlen       = CW'(1);
         end
         TX_RDB: begin
            fr.has_cmd = 1'b1;
            fr.has_rd  = 1'b1;
            rfix       = CW'(1);
         end
         TX_WRW: begin
            fr.has_cmd = 1'b1;
            wlen       = CW'(2);
         end
         TX_RDW: begin
            fr.has_cmd = 1'b1;
            fr.has_rd  = 1'b1;
            rfix       = CW'(2);
         end
         TX_PCALL: begin
            fr.has_cmd = 1'b1;
            fr.has_rd  = 1'b1;
            wlen       = CW'(2);
            rfix       = CW'(2);
         end
         TX_BWR: begin
            fr.has_cmd  = 1'b1;
            fr.has_wcnt = 1'b1;
            wlen        = blen;
         end
         TX_BRD: begin
            fr.has_cmd  = 1'b1;
            fr.has_rd   = 1'b1;
            fr.rd_block = 1'b1;
         end
         TX_BPC: begin
            fr.has_cmd  = 1'b1;
            fr.has_wcnt = 1'b1;
            fr.has_rd   = 1'b1;
            fr.rd_block = 1'b1;
            wlen        = blen;
         end
         default: known = 1'b0;
      endcase
   end

   assign rmax   = (typ == TX_BPC) ? CW'(MAX_BLOCK - 1) : CW'(MAX_BLOCK);
   assign len_ok = known && (!fr.has_wcnt || (blen != '0 && blen <= rmax));

endmodule

// File: rtl/smbus_seq_wbuf.sv
module smbus_seq_wbuf #(
   parameter int N  = 32,
   parameter int IW = $clog2(N + 1)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           load,
   input  logic [N*8-1:0] load_vec,
   input  logic [IW-1:0]  rd_idx,
   output logic [7:0]     rd_byte
);

   logic [N*8-1:0] vec_q;

   for (genvar g = 0; g < N; g++) begin : g_byte
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)    vec_q[g*8 +: 8] <= '0;
         else if (load) vec_q[g*8 +: 8] <= load_vec[g*8 +: 8];
      end
   end

   always_comb begin
      rd_byte = '0;
      for (int i = 0; i < N; i++)
         if (rd_idx == IW'(i)) rd_byte = vec_q[i*8 +: 8];
   end

endmodule

// File: rtl/smbus_seq_rbuf.sv
module smbus_seq_rbuf #(
   parameter int N  = 32,
   parameter int IW = $clog2(N + 1)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           clear,
   input  logic           wr_en,
   input  logic [IW-1:0]  wr_idx,
   input  logic [7:0]     wr_byte,
   output logic [N*8-1:0] vec
);

   for (genvar g = 0; g < N; g++) begin : g_byte
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                           vec[g*8 +: 8] <= '0;
         else if (clear)                       vec[g*8 +: 8] <= '0;
         else if (wr_en && wr_idx == IW'(g))   vec[g*8 +: 8] <= wr_byte;
      end
   end

endmodule

// File: rtl/smbus_seq_top.sv
module smbus_seq_top
   import smbus_seq_pkg::*;
#(
   parameter  int MAX_BLOCK = 32,
   localparam int CW        = $clog2(MAX_BLOCK + 1)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   req_valid,
   output logic                   req_ready,
   input  logic [3:0]             req_type,
   input  logic [6:0]             req_addr,
   input  logic [7:0]             req_cmd,
   input  logic [CW-1:0]          req_len,
   input  logic [MAX_BLOCK*8-1:0] req_wdata,
   output logic                   op_valid,
   output logic [2:0]             op_code,
   output logic [7:0]             op_byte,
   output logic                   op_nack,
   input  logic                   op_done,
   input  logic                   op_ack,
   input  logic [7:0]             op_rbyte,
   output logic                   done,
   output logic [2:0]             status,
   output logic [CW-1:0]          err_idx,
   output logic [CW-1:0]          rsp_len,
   output logic [MAX_BLOCK*8-1:0] rsp_data
);

   if (MAX_BLOCK < 2 || MAX_BLOCK > 255) begin : g_bad_param
      $error("smbus_seq_top: MAX_BLOCK must lie in 2..255");
   end

   seq_state_e    st;
   frame_t        fr_d, fr_q;
   logic [CW-1:0] wlen_d, rfix_d, rmax_d;
   logic          len_ok_d;
   logic [CW-1:0] wlen_q, rlen_q, rmax_q, idx_q, eidx_q, rcnt_q;
   logic [6:0]    addr_q;
   logic [7:0]    cmd_q;
   logic [2:0]    stat_q;
   logic          nack_q, bad_q;
   logic          accept;
   logic [7:0]    wbyte;
   logic          wr_ok;

   assign accept = req_valid && (st == S_IDLE);

   smbus_seq_frame #(.MAX_BLOCK(MAX_BLOCK), .CW(CW)) u_frame (
      .typ    (req_type),
      .blen   (req_len),
      .fr     (fr_d),
      .wlen   (wlen_d),
      .rfix   (rfix_d),
      .rmax   (rmax_d),
      .len_ok (len_ok_d)
   );

   smbus_seq_wbuf #(.N(MAX_BLOCK), .IW(CW)) u_wbuf (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (accept),
      .load_vec (req_wdata),
      .rd_idx   (idx_q),
      .rd_byte  (wbyte)
   );

   smbus_seq_rbuf #(.N(MAX_BLOCK), .IW(CW)) u_rbuf (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear   (accept),
      .wr_en   (st == S_RD && op_done),
      .wr_idx  (idx_q),
      .wr_byte (op_rbyte),
      .vec     (rsp_data)
   );

   assign wr_ok = op_done && op_ack;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= S_IDLE;
         fr_q   <= '0;
         wlen_q <= '0;
         rlen_q <= '0;
         rmax_q <= '0;
         idx_q  <= '0;
         eidx_q <= '0;
         rcnt_q <= '0;
         addr_q <= '0;
         cmd_q  <= '0;
         stat_q <= SC_OK;
         nack_q <= 1'b0;
         bad_q  <= 1'b0;
      end else begin
         case (st)
            S_IDLE: if (req_valid) begin
               fr_q   <= fr_d;
               wlen_q <= wlen_d;
               rlen_q <= rfix_d;
               rmax_q <= rmax_d;
               addr_q <= req_addr;
               cmd_q  <= req_cmd;
               idx_q  <= '0;
               eidx_q <= '0;
               rcnt_q <= '0;
               nack_q <= 1'b0;
               bad_q  <= 1'b0;
               if (len_ok_d) begin
                  stat_q <= SC_OK;
                  st     <= S_START;
               end else begin
                  stat_q <= SC_BAD_REQ;
                  st     <= S_DONE;
               end
            end
            S_START: if (op_done) st <= S_ADDR1;
            S_ADDR1: if (op_done) begin
               if (!op_ack) begin
                  stat_q <= SC_NK_ADR;
                  st     <= S_STOP;
               end
               else if (fr_q.quick)    st <= S_STOP;
               else if (fr_q.first_rd) st <= S_RD;
               else if (fr_q.has_cmd)  st <= S_CMD;
               else                    st <= S_WDATA;
            end
            S_CMD: if (op_done) begin
               if (!op_ack) begin
                  stat_q <= SC_NK_CMD;
                  st     <= S_STOP;
               end
               else if (fr_q.has_wcnt) st <= S_WCNT;
               else if (wlen_q != '0)  st <= S_WDATA;
               else if (fr_q.has_rd)   st <= S_RSTART;
               else                    st <= S_STOP;
            end
            S_WCNT: if (op_done) begin
               if (!op_ack) begin
                  stat_q <= SC_NK_CNT;
                  st     <= S_STOP;
               end
               else st <= S_WDATA;
            end
            S_WDATA: if (op_done) begin
               if (!op_ack) begin
                  stat_q <= SC_NK_DAT;
                  eidx_q <= idx_q;
                  st     <= S_STOP;
               end else if (idx_q == wlen_q - CW'(1)) begin
                  idx_q <= '0;
                  st    <= fr_q.has_rd ? S_RSTART : S_STOP;
               end else begin
                  idx_q <= idx_q + CW'(1);
               end
            end
            S_RSTART: if (op_done) st <= S_ADDR2;
            S_ADDR2: if (op_done) begin
               idx_q <= '0;
               if (!op_ack) begin
                  stat_q <= SC_NK_ADR2;
                  st     <= S_STOP;
               end
               else st <= fr_q.rd_block ? S_RCNT : S_RD;
            end
            S_RCNT: if (op_done) begin
               if (op_rbyte == 8'd0 || op_rbyte > 8'(rmax_q)) begin
                  bad_q  <= 1'b1;
                  nack_q <= 1'b1;
               end else begin
                  rlen_q <= op_rbyte[CW-1:0];
                  nack_q <= 1'b0;
               end
               st <= S_RCACK;
            end
            S_RCACK: if (op_done) begin
               if (bad_q) begin
                  stat_q <= SC_BAD_CNT;
                  st     <= S_STOP;
               end
               else st <= S_RD;
            end
            S_RD: if (op_done) begin
               rcnt_q <= rcnt_q + CW'(1);
               nack_q <= (idx_q == rlen_q - CW'(1));
               st     <= S_RDACK;
            end
            S_RDACK: if (op_done) begin
               if (nack_q) st <= S_STOP;
               else begin
                  idx_q <= idx_q + CW'(1);
                  st    <= S_RD;
               end
            end
            S_STOP:  if (op_done) st <= S_DONE;
            S_DONE:  st <= S_IDLE;
            default: st <= S_IDLE;
         endcase
      end
   end

   always_comb begin
      op_valid = 1'b1;
      op_code  = OP_STOP;
      op_byte  = 8'h00;
      op_nack  = 1'b0;
      case (st)
         S_START:  op_code = OP_START;
         S_ADDR1: begin
            op_code = OP_WRITE;
            op_byte = {addr_q, fr_q.first_rd | (fr_q.quick & cmd_q[0])};
         end
         S_CMD: begin
            op_code = OP_WRITE;
            op_byte = cmd_q;
         end
         S_WCNT: begin
            op_code = OP_WRITE;
            op_byte = 8'(wlen_q);
         end
         S_WDATA: begin
            op_code = OP_WRITE;
            op_byte = wbyte;
         end
         S_RSTART: op_code = OP_RSTART;
         S_ADDR2: begin
            op_code = OP_WRITE;
            op_byte = {addr_q, 1'b1};
         end
         S_RCNT, S_RD: op_code = OP_READ;
         S_RCACK, S_RDACK: begin
            op_code = OP_ACK;
            op_nack = nack_q;
         end
         S_STOP: op_code = OP_STOP;
         default: op_valid = 1'b0;
      endcase
   end

   assign req_ready = (st == S_IDLE);
   assign done      = (st == S_DONE);
   assign status    = stat_q;
   assign err_idx   = eidx_q;
   assign rsp_len   = rcnt_q;

   // R1: a taken request makes the block busy
   a_r1_busy_after_take: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !req_ready);

   // R1: completion pulse lasts one cycle and returns to ready
   a_r1_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (!done && req_ready));

   // R2: a pending primitive does not change before the engine closes it
   a_r2_op_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && !op_done) |=> (op_valid && $stable(op_code) &&
                                  $stable(op_byte) && $stable(op_nack)));

   // R9: never more read bytes than the buffer holds
   a_r9_len_bound: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_len <= CW'(MAX_BLOCK));

   // R11: a refused write byte is followed by stop
   a_r11_nack_stops: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_code == OP_WRITE && op_done && !op_ack)
      |=> (op_valid && op_code == OP_STOP));

   // R6, R12: a NACK sent by the host is followed by stop
   a_r12_host_nack_stops: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_code == OP_ACK && op_nack && op_done)
      |=> (op_valid && op_code == OP_STOP));

endmodule

// File: tb/tb_smbus_seq_top.sv
module tb_smbus_seq_top;
   import smbus_seq_pkg::*;

   localparam int CLK_PERIOD = 10;
   localparam int MB = 32;
   localparam int CW = $clog2(MB + 1);

   logic            clk, rst_n;
   logic            req_valid, req_ready;
   logic [3:0]      req_type;
   logic [6:0]      req_addr;
   logic [7:0]      req_cmd;
   logic [CW-1:0]   req_len;
   logic [MB*8-1:0] req_wdata;
   logic            op_valid, op_nack, op_done, op_ack;
   logic [2:0]      op_code;
   logic [7:0]      op_byte, op_rbyte;
   logic            done;
   logic [2:0]      status;
   logic [CW-1:0]   err_idx, rsp_len;
   logic [MB*8-1:0] rsp_data;

   smbus_seq_top #(.MAX_BLOCK(MB)) dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_type(req_type), .req_addr(req_addr), .req_cmd(req_cmd),
      .req_len(req_len), .req_wdata(req_wdata), .op_valid(op_valid),
      .op_code(op_code), .op_byte(op_byte), .op_nack(op_nack),
      .op_done(op_done), .op_ack(op_ack), .op_rbyte(op_rbyte), .done(done),
      .status(status), .err_idx(err_idx), .rsp_len(rsp_len),
      .rsp_data(rsp_data)
   );

   initial clk = 1'b0;
   always #(CLK_PERIOD/2) clk = ~clk;

   int          n_chk = 0;
   int          n_bad = 0;
   logic [10:0] exp_q[$];
   logic [7:0]  rb[$];
   logic [7:0]  wd[MB];
   int          nack_at = -1;
   int          wcnt = 0;
   string       rq_cur = "R1";

   task automatic chk(input bit ok, input string rq, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
      end
   endtask

   task automatic push(input logic [2:0] c, input logic [7:0] b);
      exp_q.push_back({c, b});
   endtask

   task automatic pw(input logic [7:0] b, input int nk, inout bit ab, inout int wn);
      if (!ab) begin
         push(OP_WRITE, b);
         if (wn == nk) ab = 1'b1;
         wn++;
      end
   endtask

   // monitor: bit-engine model, pops and compares each primitive
   initial begin
      op_done  = 1'b0;
      op_ack   = 1'b0;
      op_rbyte = 8'h00;
      forever begin
         @(negedge clk);
         if (op_done) op_done = 1'b0;
         else if (rst_n && op_valid) begin : one_op
            logic [10:0] e;
            if (exp_q.size() == 0) begin
               chk(1'b0, {rq_cur, " unexpected primitive"}, op_code, 7);
            end else begin
               e = exp_q.pop_front();
               chk(op_code == e[10:8], {rq_cur, " primitive code"}, op_code, e[10:8]);
               if (e[10:8] == OP_WRITE)
                  chk(op_byte == e[7:0], {rq_cur, " written byte"}, op_byte, e[7:0]);
               if (e[10:8] == OP_ACK)
                  chk(op_nack == e[0], {rq_cur, " ack choice"}, op_nack, e[0]);
            end
            if (op_code == OP_WRITE) begin
               op_ack = (wcnt != nack_at);
               wcnt++;
            end
            if (op_code == OP_READ)
               op_rbyte = (rb.size() != 0) ? rb.pop_front() : 8'h00;
            op_done = 1'b1;
         end
      end
   end

   // driver: builds the expected primitive list, then issues the request
   task automatic run(input logic [3:0] t, input logic [6:0] a, input logic [7:0] c,
                      input int len, input int nk, input logic [2:0] es,
                      input int eidx, input string rq);
      logic [7:0] erb[$];
      bit ab, badreq, hasrd, blkrd, blkw;
      int wn, nw, nr, off, cnt, lim, erl;
      erb = rb; ab = 0; wn = 0; nr = 0; off = 0; nw = 0;
      nack_at = nk; wcnt = 0; rq_cur = rq;
      blkw  = (t == TX_BWR || t == TX_BPC);
      blkrd = (t == TX_BRD || t == TX_BPC);
      lim   = (t == TX_BPC) ? MB - 1 : MB;
      badreq = (t > 4'd10) || (blkw && (len == 0 || len > lim));
      hasrd = (t == TX_RECV || t == TX_RDB || t == TX_RDW || t == TX_PCALL || blkrd);
      case (t)
         TX_SEND, TX_WRB:   nw = 1;
         TX_WRW, TX_PCALL:  nw = 2;
         TX_BWR, TX_BPC:    nw = len;
         default:           nw = 0;
      endcase
      case (t)
         TX_RECV, TX_RDB:   nr = 1;
         TX_RDW, TX_PCALL:  nr = 2;
         default:           nr = 0;
      endcase
      if (!badreq) begin
         push(OP_START, 8'h00);
         if (t == TX_QUICK)     pw({a, c[0]}, nk, ab, wn);
         else if (t == TX_RECV) pw({a, 1'b1}, nk, ab, wn);
         else                   pw({a, 1'b0}, nk, ab, wn);
         if (t != TX_QUICK && t != TX_SEND && t != TX_RECV) pw(c, nk, ab, wn);
         if (blkw) pw(8'(len), nk, ab, wn);
         for (int k = 0; k < nw; k++) pw(wd[k], nk, ab, wn);
         if (hasrd && !ab) begin
            if (t != TX_RECV) begin
               push(OP_RSTART, 8'h00);
               pw({a, 1'b1}, nk, ab, wn);
            end
            if (!ab && blkrd) begin
               cnt = erb[0];
               push(OP_READ, 8'h00);
               if (cnt == 0 || cnt > lim) begin
                  push(OP_ACK, 8'h01);
                  ab = 1'b1;
               end else begin
                  push(OP_ACK, 8'h00);
                  nr = cnt; off = 1;
               end
            end
            if (!ab)
               for (int k = 0; k < nr; k++) begin
                  push(OP_READ, 8'h00);
                  push(OP_ACK, (k == nr - 1) ? 8'h01 : 8'h00);
               end
         end
         push(OP_STOP, 8'h00);
      end
      erl = (es == SC_OK) ? nr : 0;

      @(negedge clk);
      req_type = t; req_addr = a; req_cmd = c; req_len = CW'(len);
      for (int k = 0; k < MB; k++) req_wdata[k*8 +: 8] = wd[k];
      req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      while (!done) @(negedge clk);
      chk(status == es, {rq, " status"}, status, es);
      chk(err_idx == CW'(eidx), {rq, " err_idx"}, err_idx, eidx);
      chk(rsp_len == CW'(erl), {rq, " rsp_len"}, rsp_len, erl);
      for (int k = 0; k < erl; k++)
         chk(rsp_data[k*8 +: 8] == erb[off + k], {rq, " read byte"},
             rsp_data[k*8 +: 8], erb[off + k]);
      chk(exp_q.size() == 0, {rq, " primitives left over"}, exp_q.size(), 0);
      exp_q.delete();
      @(negedge clk);
      chk(req_ready == 1'b1, "R1 ready after done", req_ready, 1);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      chk(1'b0, "watchdog expired", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      rst_n = 1'b0; req_valid = 1'b0; req_type = '0; req_addr = '0;
      req_cmd = '0; req_len = '0; req_wdata = '0;
      for (int k = 0; k < MB; k++) wd[k] = 8'(k * 7 + 3);
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(req_ready == 1'b1, "R1 reset ready", req_ready, 1);
      chk(op_valid == 1'b0,  "R1 reset op_valid", op_valid, 0);
      chk(done == 1'b0,      "R1 reset done", done, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R3 quick, both directions
      rb = {}; run(TX_QUICK, 7'h2A, 8'h00, 0, -1, SC_OK, 0, "R3 quick wr");
      rb = {}; run(TX_QUICK, 7'h2A, 8'h01, 0, -1, SC_OK, 0, "R3 quick rd");
      // R4 send / receive
      wd[0] = 8'hA5; rb = {};
      run(TX_SEND, 7'h10, 8'h00, 0, -1, SC_OK, 0, "R4 send");
      rb = {8'h3C}; run(TX_RECV, 7'h11, 8'h00, 0, -1, SC_OK, 0, "R4 receive");
      // R5 byte / word write
      wd[0] = 8'h5A; rb = {};
      run(TX_WRB, 7'h20, 8'h07, 0, -1, SC_OK, 0, "R5 byte write");
      wd[0] = 8'h34; wd[1] = 8'h12;
      run(TX_WRW, 7'h22, 8'h0B, 0, -1, SC_OK, 0, "R5 word write");
      // R6 byte / word read
      rb = {8'hC3}; run(TX_RDB, 7'h21, 8'h09, 0, -1, SC_OK, 0, "R6 byte read");
      rb = {8'h78, 8'h56}; run(TX_RDW, 7'h23, 8'h0C, 0, -1, SC_OK, 0, "R6 word read");
      // R7 process call
      wd[0] = 8'hEF; wd[1] = 8'hBE; rb = {8'hAD, 8'hDE};
      run(TX_PCALL, 7'h30, 8'h44, 0, -1, SC_OK, 0, "R7 process call");
      // R8 block write
      wd[0] = 8'h01; wd[1] = 8'h02; wd[2] = 8'h03; rb = {};
      run(TX_BWR, 7'h31, 8'h50, 3, -1, SC_OK, 0, "R8 block write");
      // R9 block read, short and full size
      rb = {8'd4, 8'h11, 8'h22, 8'h33, 8'h44};
      run(TX_BRD, 7'h32, 8'h51, 0, -1, SC_OK, 0, "R9 block read");
      rb = {8'd32};
      for (int k = 0; k < 32; k++) rb.push_back(8'(8'hC0 + k));
      run(TX_BRD, 7'h33, 8'h52, 0, -1, SC_OK, 0, "R9 block read max");
      // R10 block process call
      wd[0] = 8'h9A; wd[1] = 8'hBC; rb = {8'd3, 8'h09, 8'h08, 8'h07};
      run(TX_BPC, 7'h34, 8'h53, 2, -1, SC_OK, 0, "R10 block proc call");
      // R11 NACK at each write position
      rb = {}; run(TX_WRB, 7'h40, 8'h01, 0, 0, SC_NK_ADR, 0, "R11 nack address");
      rb = {}; run(TX_RDB, 7'h41, 8'h02, 0, 1, SC_NK_CMD, 0, "R11 nack command");
      wd[0] = 8'h34; wd[1] = 8'h12;
      run(TX_WRW, 7'h42, 8'h03, 0, 3, SC_NK_DAT, 1, "R11 nack data 1");
      run(TX_BWR, 7'h43, 8'h04, 2, 2, SC_NK_CNT, 0, "R11 nack count");
      rb = {}; run(TX_RDW, 7'h44, 8'h05, 0, 2, SC_NK_ADR2, 0, "R11 nack read address");
      // R12 bad returned counts
      rb = {8'd0};  run(TX_BRD, 7'h50, 8'h06, 0, -1, SC_BAD_CNT, 0, "R12 count zero");
      rb = {8'd33}; run(TX_BRD, 7'h51, 8'h07, 0, -1, SC_BAD_CNT, 0, "R12 count too big");
      rb = {8'd32}; run(TX_BPC, 7'h52, 8'h08, 1, -1, SC_BAD_CNT, 0, "R12 bpc count 32");
      // R8 rejected requests
      rb = {}; run(TX_BWR, 7'h60, 8'h09, 0, -1, SC_BAD_REQ, 0, "R8 block len 0");
      rb = {}; run(TX_BPC, 7'h61, 8'h0A, 32, -1, SC_BAD_REQ, 0, "R8 bpc len 32");
      rb = {}; run(4'd12, 7'h62, 8'h0B, 0, -1, SC_BAD_REQ, 0, "R8 unknown type");

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule